// File: doc/BRIEF.md
# Instrument Status Reporting Register Unit

This block keeps the status picture that a bus-controlled instrument shows to its host. An eight-bit event register records single-cycle event pulses from the device as sticky bits. The host reads the register and clears it in the same operation, or clears it with a separate strobe. An eight-bit event enable mask selects which of these bits feed a one-bit event summary.

The event summary sits in a status byte together with three other inputs:
- a message-available bit, taken from the empty flag of an output queue that lies outside the block;
- five auxiliary summary bits from other status structures;
- a request-service bit.

A second eight-bit mask, the service-request enable, picks which status byte bits can raise a service request. The request-service bit is registered, appears in the status byte and drives the SRQ output. The host writes both masks through one shared data bus with separate write strobes.

Top module: `status_report_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, the event register reads 0x80 (power-on set) and both enable masks are zero. As a result the status byte reads 0x00 and `srq` is 0 until the host writes a mask.
- R2: A pulse on `evt_pulse[i]` sets event bit i at the next clock edge. The fixed mapping is: bit 0 operation complete, bit 1 request control, bit 2 query error, bit 3 device-dependent error, bit 4 execution error, bit 5 command error, bit 6 user request, bit 7 power on.
- R3: Event bits that are set stay set through any number of cycles that carry no read or clear strobe.
- R4: In a cycle with `esr_rd` high, `esr_rdata` shows the register value before the clear, and the register is zero after the edge. If an event pulse arrives in that same cycle, its bit is set after the edge and is not lost.
- R5: Status byte bit 5 is 1 exactly when the bitwise AND of the event register and the event enable mask is non-zero. It follows the registers with no added delay.
- R6: Status byte bit 4 is the inverse of `queue_empty`, with no delay.
- R7: `aux_summary[3:0]` appear on status byte bits 3..0, and `aux_summary[4]` appears on bit 7, with no delay.
- R8: `srq` and status byte bit 6 rise at the edge after the masked summary (status bits 0..5 and 7 ANDed with the service-request enable) becomes non-zero. They fall at the edge after it becomes zero.
- R9: Bit 6 of the service-request enable has no effect. A mask of 0x40 never raises `srq`.
- R10: A pulse on `evt_clr` zeroes the event register at the next edge. An event pulse in the same cycle still sets its bit. Mask writes take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 8 | Single-cycle device event pulses, one per event bit |
| queue_empty | input | 1 | Empty flag of the output queue |
| aux_summary | input | 5 | Other summary messages, mapped to status bits 0..3 and 7 |
| ese_wr | input | 1 | Write strobe for the event enable mask |
| sre_wr | input | 1 | Write strobe for the service-request enable mask |
| host_wdata | input | 8 | Shared write data for both masks |
| esr_rd | input | 1 | Read-and-clear strobe for the event register |
| evt_clr | input | 1 | Clear strobe for the event register |
| esr_rdata | output | 8 | Current event register contents |
| stb_rdata | output | 8 | Status byte, live, with bit 6 the request-service state |
| srq | output | 1 | Service request to the external controller |

## Verification
The case of most interest is a device event pulse that lands in the same cycle as a host read-and-clear, or as a clear strobe. The bench drives both in one cycle. It then checks that the read data in that cycle carries only the older bits, and that after the edge the register holds exactly the bit of the new pulse. A second overlap is a service-request summary that collapses in the same cycle as a read-and-clear. It is judged by `srq` staying high through that edge and dropping one edge later.

// File: rtl/status_pkg.sv
// Package: shared bit positions and helpers for the status reporting unit.
// Assumes an eight-bit status byte; positions of the fixed summaries are
// behavioural, since the host decodes them.
package status_pkg;

    localparam int STB_W       = 8;
    localparam int EVT_W       = 8;
    localparam int AUX_W       = 5;
    localparam int STB_BIT_MAV = 4;
    localparam int STB_BIT_ESB = 5;
    localparam int STB_BIT_RQS = 6;

    // Event register bit indices.
    typedef enum int {
        EV_OP_DONE   = 0,
        EV_REQ_CTRL  = 1,
        EV_QUERY_ERR = 2,
        EV_DEV_ERR   = 3,
        EV_EXEC_ERR  = 4,
        EV_CMD_ERR   = 5,
        EV_USER_REQ  = 6,
        EV_POWER_ON  = 7
    } evt_idx_e;

    // Status byte position of auxiliary summary j: fills positions not
    // reserved for MAV, ESB and RQS, lowest first.
    function automatic int aux_pos(input int j);
        return (j < STB_BIT_MAV) ? j : j + 3;
    endfunction

endpackage

// File: rtl/evt_status_reg.sv
// Module: event status register with its enable mask.
// Holds sticky event bits set by single-cycle pulses; a read strobe or a
// clear strobe zeroes them, but a pulse in the same cycle wins. Produces the
// masked OR summary. Assumes pulses are synchronous to clk.
module evt_status_reg #(
    parameter int EVT_W   = 8,
    parameter int PON_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_pulse,
    input  logic             rd_clr,
    input  logic             clr,
    input  logic             ese_wr,
    input  logic [EVT_W-1:0] ese_wdata,
    output logic [EVT_W-1:0] esr_q,
    output logic             esb
);

    logic [EVT_W-1:0] ese_q;
    logic             wipe;

    assign wipe = rd_clr | clr;

    // One sticky cell per event bit.
    for (genvar i = 0; i < EVT_W; i++) begin : g_cell
        logic bit_q;
        // Set on pulse, clear on wipe, power-on bit set by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= (i == PON_BIT);
            else if (evt_pulse[i])
                bit_q <= 1'b1;
            else if (wipe)
                bit_q <= 1'b0;
        end
        assign esr_q[i] = bit_q;
    end

    // Event enable mask, host written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ese_q <= '0;
        else if (ese_wr)
            ese_q <= ese_wdata;
    end

    // Masked OR summary.
    assign esb = |(esr_q & ese_q);

    AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((esr_q & $past(evt_pulse)) == $past(evt_pulse))); // R2
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !clr) |=> ((esr_q & $past(esr_q)) == $past(esr_q))); // R3
    AST_EVT_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_clr || clr) && evt_pulse == '0) |=> (esr_q == '0)); // R4

endmodule

// File: rtl/svc_request_gen.sv
// Module: service-request enable mask and request-service flag.
// Registers the OR of the status summary ANDed with the enable mask; the
// request-service position is excluded so the flag cannot hold itself.
module svc_request_gen #(
    parameter int STB_W   = 8,
    parameter int RQS_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STB_W-1:0] summary,
    input  logic             sre_wr,
    input  logic [STB_W-1:0] sre_wdata,
    output logic             rqs_q
);

    localparam logic [STB_W-1:0] RQS_KEEP = ~(STB_W'(1) << RQS_BIT);

    logic [STB_W-1:0] sre_q;
    logic             want;

    // Service-request enable mask, host written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sre_q <= '0;
        else if (sre_wr)
            sre_q <= sre_wdata;
    end

    // Masked summary with the self position removed.
    assign want = |(summary & sre_q & RQS_KEEP);

    // Request-service flag follows the masked summary one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rqs_q <= 1'b0;
        else
            rqs_q <= want;
    end

    AST_SRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        want |=> rqs_q); // R8
    AST_SRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !want |=> !rqs_q); // R8
    AST_SELF_MASK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        ((summary & sre_q & RQS_KEEP) == '0 && $stable(sre_q)) |=> !rqs_q); // R9

endmodule

// File: rtl/status_report_unit.sv
// Module: top of the status reporting unit.
// Builds the status byte from the event summary, the queue non-empty flag,
// auxiliary summaries and the request-service flag, and drives SRQ.
// Assumes queue_empty and aux_summary are synchronous to clk.
module status_report_unit
    import status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_pulse,
    input  logic             queue_empty,
    input  logic [AUX_W-1:0] aux_summary,
    input  logic             ese_wr,
    input  logic             sre_wr,
    input  logic [STB_W-1:0] host_wdata,
    input  logic             esr_rd,
    input  logic             evt_clr,
    output logic [EVT_W-1:0] esr_rdata,
    output logic [STB_W-1:0] stb_rdata,
    output logic             srq
);

    logic             esb;
    logic             rqs;
    logic [STB_W-1:0] sum_byte;

    evt_status_reg #(.EVT_W(EVT_W), .PON_BIT(EV_POWER_ON)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .rd_clr    (esr_rd),
        .clr       (evt_clr),
        .ese_wr    (ese_wr),
        .ese_wdata (host_wdata),
        .esr_q     (esr_rdata),
        .esb       (esb)
    );

    // Auxiliary summaries placed into the free status positions.
    for (genvar j = 0; j < AUX_W; j++) begin : g_aux
        assign sum_byte[aux_pos(j)] = aux_summary[j];
    end
    assign sum_byte[STB_BIT_MAV] = ~queue_empty;
    assign sum_byte[STB_BIT_ESB] = esb;
    assign sum_byte[STB_BIT_RQS] = 1'b0;

    svc_request_gen #(.STB_W(STB_W), .RQS_BIT(STB_BIT_RQS)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .summary   (sum_byte),
        .sre_wr    (sre_wr),
        .sre_wdata (host_wdata),
        .rqs_q     (rqs)
    );

    // Status byte readout: live summaries plus the registered request flag.
    always_comb begin
        stb_rdata              = sum_byte;
        stb_rdata[STB_BIT_RQS] = rqs;
    end

    assign srq = rqs;

    AST_PON_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> esr_rdata[EV_POWER_ON]); // R1
    AST_MAV_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(queue_empty) |-> stb_rdata[STB_BIT_MAV]); // R6

endmodule

// File: tb/status_report_unit_bench.sv
`timescale 1ns/1ps
module status_report_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] evt_pulse;
    logic       queue_empty;
    logic [4:0] aux_summary;
    logic       ese_wr, sre_wr;
    logic [7:0] host_wdata;
    logic       esr_rd, evt_clr;
    logic [7:0] esr_rdata, stb_rdata;
    logic       srq;

    int nrun  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    status_report_unit u_status_report_unit (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .queue_empty(queue_empty), .aux_summary(aux_summary),
        .ese_wr(ese_wr), .sre_wr(sre_wr), .host_wdata(host_wdata),
        .esr_rd(esr_rd), .evt_clr(evt_clr), .esr_rdata(esr_rdata),
        .stb_rdata(stb_rdata), .srq(srq)
    );

    typedef struct packed {
        logic [7:0] evt;
        logic       qe;
        logic [4:0] aux;
        logic       ew;
        logic       sw;
        logic [7:0] wd;
        logic       rd;
        logic       clr;
        logic [7:0] x_esr;
        logic [7:0] x_stb;
        logic       x_srq;
    } vec_t;

    // Each row: inputs for one cycle, outputs expected after its edge.
    localparam vec_t TBL [19] = '{
        '{8'h00,1'b1,5'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 8'h00,8'h00,1'b0}, // R4 read clears PON
        '{8'h01,1'b1,5'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h01,8'h00,1'b0}, // R2 op done
        '{8'h00,1'b1,5'h00,1'b1,1'b0,8'h01,1'b0,1'b0, 8'h01,8'h20,1'b0}, // R5 enable write
        '{8'h00,1'b1,5'h00,1'b0,1'b1,8'h20,1'b0,1'b0, 8'h01,8'h20,1'b0}, // R10 mask next edge
        '{8'h00,1'b1,5'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h01,8'h60,1'b1}, // R8 rise
        '{8'h00,1'b1,5'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 8'h00,8'h40,1'b1}, // R8 still high
        '{8'h00,1'b1,5'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h00,8'h00,1'b0}, // R8 fall
        '{8'h00,1'b0,5'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h00,8'h10,1'b0}, // R6 MAV
        '{8'h00,1'b0,5'h00,1'b0,1'b1,8'h10,1'b0,1'b0, 8'h00,8'h10,1'b0}, // R8 MAV mask
        '{8'h00,1'b0,5'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h00,8'h50,1'b1}, // R8 MAV raises
        '{8'h00,1'b1,5'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h00,8'h00,1'b0}, // R8 queue empties
        '{8'h00,1'b1,5'h00,1'b0,1'b1,8'h40,1'b0,1'b0, 8'h00,8'h00,1'b0}, // R9 self-bit mask
        '{8'h00,1'b0,5'h1F,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h00,8'h9F,1'b0}, // R7 aux, R9
        '{8'h00,1'b0,5'h1F,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h00,8'h9F,1'b0}, // R9 stays low
        '{8'h00,1'b0,5'h1F,1'b0,1'b1,8'hFF,1'b0,1'b0, 8'h00,8'h9F,1'b0}, // R10 mask write
        '{8'h00,1'b0,5'h1F,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h00,8'hDF,1'b1}, // R8 all bits
        '{8'h00,1'b1,5'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h00,8'h00,1'b0}, // R8 fall
        '{8'hFE,1'b1,5'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'hFE,8'h00,1'b0}, // R2 multi pulse
        '{8'h00,1'b1,5'h00,1'b0,1'b0,8'h00,1'b0,1'b1, 8'h00,8'h00,1'b0}  // R10 clear
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        nrun++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_in(input logic [7:0] evt, input logic qe,
                          input logic [4:0] aux, input logic ew,
                          input logic sw, input logic [7:0] wd,
                          input logic rd, input logic clr);
        evt_pulse = evt; queue_empty = qe; aux_summary = aux;
        ese_wr = ew; sre_wr = sw; host_wdata = wd; esr_rd = rd; evt_clr = clr;
    endtask

    task automatic idle();
        set_in(8'h00, 1'b1, 5'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "esr after reset", esr_rdata, 8'h80);
        chk("R1", "stb after reset", stb_rdata, 8'h00);
        chk("R1", "srq after reset", {7'd0, srq}, 8'h00);

        // Vector table walk.
        for (int i = 0; i < 19; i++) begin
            set_in(TBL[i].evt, TBL[i].qe, TBL[i].aux, TBL[i].ew,
                   TBL[i].sw, TBL[i].wd, TBL[i].rd, TBL[i].clr);
            @(negedge clk);
            chk($sformatf("row%0d", i), "esr", esr_rdata, TBL[i].x_esr);
            chk($sformatf("row%0d", i), "stb", stb_rdata, TBL[i].x_stb);
            chk($sformatf("row%0d", i), "srq", {7'd0, srq}, {7'd0, TBL[i].x_srq});
        end
        // State now: esr 0, event mask 0x01, request mask 0xFF.

        // R3 sticky: one pulse then idle cycles.
        set_in(8'h01, 1'b1, 5'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        chk("R5", "stb after pulse", stb_rdata, 8'h20);
        idle();
        @(negedge clk);
        chk("R8", "stb with rqs", stb_rdata, 8'h60);
        repeat (3) @(negedge clk);
        chk("R3", "esr held", esr_rdata, 8'h01);

        // R4 collision: read-and-clear with a new pulse in the same cycle.
        set_in(8'h08, 1'b1, 5'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        #1;
        chk("R4", "read data in strobe cycle", esr_rdata, 8'h01);
        @(negedge clk);
        chk("R4", "esr keeps colliding pulse", esr_rdata, 8'h08);
        chk("R8", "srq held through edge", {7'd0, srq}, 8'h01);
        idle();
        @(negedge clk);
        chk("R8", "srq one edge later", {7'd0, srq}, 8'h00);

        // R10 collision: clear strobe with a pulse in the same cycle.
        set_in(8'h10, 1'b1, 5'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        @(negedge clk);
        chk("R10", "clear keeps colliding pulse", esr_rdata, 8'h10);
        set_in(8'h00, 1'b1, 5'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        @(negedge clk);
        chk("R10", "clear alone", esr_rdata, 8'h00);

        // R2 mapping and R5 summary per event bit.
        for (int b = 0; b < 8; b++) begin
            set_in(8'(1 << b), 1'b1, 5'h00, 1'b1, 1'b0, 8'(1 << b), 1'b0, 1'b0);
            @(negedge clk);
            chk("R2", $sformatf("bit %0d set", b), esr_rdata, 8'(1 << b));
            chk("R5", $sformatf("esb on bit %0d", b), {7'd0, stb_rdata[5]}, 8'h01);
            set_in(8'h00, 1'b1, 5'h00, 1'b1, 1'b0, ~8'(1 << b), 1'b0, 1'b0);
            @(negedge clk);
            chk("R5", $sformatf("esb off bit %0d", b), {7'd0, stb_rdata[5]}, 8'h00);
            set_in(8'h00, 1'b1, 5'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
            @(negedge clk);
        end

        // R1 reset mid-run with both masks set.
        set_in(8'h0F, 1'b1, 5'h00, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0);
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "esr after re-reset", esr_rdata, 8'h80);
        @(negedge clk);
        chk("R1", "stb masks cleared", stb_rdata, 8'h00);
        chk("R1", "srq masks cleared", {7'd0, srq}, 8'h00);

        finish_run();
    end

endmodule